// File: doc/BRIEF.md
# IF Sample Stream Deframer

This block sits behind the digitizing receiver back end and turns its continuous serial output into parallel samples. Each bit arrives on a complementary pair of lines and is clocked by a clock that the back end supplies. That clock runs at a nominal 2.4 MHz, but it can start at 4.8 MHz until the back end is reprogrammed. The block runs entirely in that clock domain, so a change of bit rate needs no handling beyond the frame length.

A frame starts with a fixed 8-bit marker, with no separate frame pin. The marker is followed by a 16-bit in-phase word, a 16-bit quadrature word and a 9-bit gain word. A number of fill bits then follows, and that number depends on the sampling speed. The block hunts for the marker and confirms it one frame later. Once locked, it extracts the three fields and presents them together with a one-cycle valid strobe. It drops lock as soon as a marker fails to appear where one is expected.

The fill count is an input that the surrounding logic sets to match the sampling speed. The block takes a new value of this input at each marker it accepts.

Top module: `if_deframer`

## Requirements
- R1: A bit is read as 1 when `dinP`=1 and `dinN`=0, and as 0 when `dinP`=0 and `dinN`=1.
- R2: A frame is the marker 8'hA7, then I (16 bits), then Q (16 bits), then gain (9 bits), then F fill bits, for a total of 49+F bits. Every field is sent MSB first. A published sample carries exactly the I, Q and gain values of its frame.
- R3: In the unlocked state, finding the marker starts a candidate frame. `locked` goes to 1 only if the next marker ends exactly 49+F bits later. A marker off by even one bit sends the block back to hunting, and lock does not go to 1.
- R4: No sample is published while unlocked. The first sample published is the frame whose marker confirmed the lock. `sampleValid` is only ever high while `locked` is 1.
- R5: Each accepted frame raises `sampleValid` for exactly one cycle. `iWord`, `qWord` and `gainWord` change together on that pulse and hold their values otherwise.
- R6: `fillCount` (0 to 63) is sampled at each accepted marker and sets the fill length of the frame that follows. Changing it from frame to frame while locked keeps lock and samples flowing, for every value from 0 to 63.
- R7: While locked, a missing marker at the expected position clears `locked` and discards that frame. Two good markers at the correct spacing are then needed before samples resume.
- R8: When `dinP` equals `dinN` on any I, Q or gain bit, that frame's sample is not published and lock is kept. The same condition on a fill bit has no effect on the sample.
- R9: After reset, `locked`, `sampleValid`, `iWord`, `qWord` and `gainWord` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock supplied by the back end |
| rstN | input | 1 | Active-low synchronous reset |
| dinP | input | 1 | True side of the differential data pair |
| dinN | input | 1 | Complement side of the differential data pair |
| fillCount | input | 6 | Number of fill bits per frame |
| iWord | output | 16 | Last published in-phase word |
| qWord | output | 16 | Last published quadrature word |
| gainWord | output | 9 | Last published gain word |
| sampleValid | output | 1 | One-cycle pulse when a new sample is published |
| locked | output | 1 | Frame synchronization is held |

## Verification
The main run locks once and then sweeps the fill count through all 64 values, one frame each, in a scrambled order, with field values computed per frame. Any error in frame length, in where a field starts, or in bit order shows up there as a wrong word or as lost lock.

Separate frames inject a line error on an I bit, on the last gain bit and on a fill bit. These tell apart suppression over the field range from suppression of the whole frame. A zeroed marker while locked checks that lock drops and that re-acquisition needs two markers. A single stray bit between two frames checks that a marker at the wrong spacing is not taken as confirmation.

// File: rtl/deframer_pkg.sv
package deframer_pkg;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_CONFIRM,
    ST_LOCK
  } lockState_t;

  typedef struct packed {
    logic shiftI;
    logic shiftQ;
    logic shiftG;
    logic publish;
  } dfStrobes_t;

endpackage

// File: rtl/deframer_datapath.sv
module deframer_datapath
  import deframer_pkg::*;
#(
  parameter int SYNC_W = 8,
  parameter logic [SYNC_W-1:0] SYNC_PAT = 8'hA7,
  parameter int I_W = 16,
  parameter int Q_W = 16,
  parameter int G_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dinP,
  input  logic             dinN,
  input  dfStrobes_t       strobe,
  output logic             markerSeen,
  output logic             bitErr,
  output logic [I_W-1:0]   iWord,
  output logic [Q_W-1:0]   qWord,
  output logic [G_W-1:0]   gainWord,
  output logic             sampleValid
);

  logic [SYNC_W-1:0] syncSh;
  logic [I_W-1:0]    iSh;
  logic [Q_W-1:0]    qSh;
  logic [G_W-2:0]    gSh;
  logic              newBit;

  // the newest decided bit, one cycle behind the pins
  assign newBit     = syncSh[0];
  assign markerSeen = (syncSh == SYNC_PAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncSh <= '0;
      bitErr <= 1'b0;
    end else begin
      syncSh <= {syncSh[SYNC_W-2:0], dinP};
      bitErr <= (dinP == dinN);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iSh <= '0;
      qSh <= '0;
      gSh <= '0;
    end else begin
      if (strobe.shiftI) iSh <= {iSh[I_W-2:0], newBit};
      if (strobe.shiftQ) qSh <= {qSh[Q_W-2:0], newBit};
      if (strobe.shiftG) gSh <= {gSh[G_W-3:0], newBit};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iWord       <= '0;
      qWord       <= '0;
      gainWord    <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobe.publish;
      if (strobe.publish) begin
        iWord    <= iSh;
        qWord    <= qSh;
        gainWord <= {gSh, newBit};
      end
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ($stable(iWord) && $stable(qWord) && $stable(gainWord))); // R5

endmodule

// File: rtl/deframer_control.sv
module deframer_control
  import deframer_pkg::*;
#(
  parameter int SYNC_W = 8,
  parameter int I_W = 16,
  parameter int Q_W = 16,
  parameter int G_W = 9,
  parameter int FILL_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              markerSeen,
  input  logic              bitErr,
  input  logic [FILL_W-1:0] fillCount,
  output dfStrobes_t        strobe,
  output logic              locked
);

  localparam int DATA_BITS = I_W + Q_W + G_W;
  localparam int BASE_LEN  = DATA_BITS + SYNC_W;
  localparam int POS_W     = $clog2(BASE_LEN + (1 << FILL_W));
  localparam logic [POS_W-1:0] I_END  = POS_W'(I_W);
  localparam logic [POS_W-1:0] Q_END  = POS_W'(I_W + Q_W);
  localparam logic [POS_W-1:0] D_END  = POS_W'(DATA_BITS);
  localparam logic [POS_W-1:0] G_LAST = POS_W'(DATA_BITS - 1);
  localparam logic [POS_W-1:0] BASE_M1 = POS_W'(BASE_LEN - 1);

  lockState_t        state;
  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  lastPos;
  logic [FILL_W-1:0] fillLat;
  logic              frameBad;
  logic              inFrame;
  logic              atEnd;
  logic              inData;

  assign lastPos = BASE_M1 + POS_W'(fillLat);
  assign inFrame = (state != ST_HUNT);
  assign atEnd   = (pos == lastPos);
  assign inData  = (pos < D_END);
  assign locked  = (state == ST_LOCK);

  always_comb begin
    strobe.shiftI  = inFrame && (pos < I_END);
    strobe.shiftQ  = inFrame && (pos >= I_END) && (pos < Q_END);
    strobe.shiftG  = inFrame && (pos >= Q_END) && inData;
    strobe.publish = (state == ST_LOCK) && (pos == G_LAST) && !frameBad && !bitErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      pos      <= '0;
      fillLat  <= '0;
      frameBad <= 1'b0;
    end else begin
      case (state)
        ST_HUNT: begin
          if (markerSeen) begin
            state    <= ST_CONFIRM;
            pos      <= '0;
            fillLat  <= fillCount;
            frameBad <= 1'b0;
          end
        end
        default: begin
          if (atEnd) begin
            if (markerSeen) begin
              state    <= ST_LOCK;
              pos      <= '0;
              fillLat  <= fillCount;
              frameBad <= 1'b0;
            end else begin
              state <= ST_HUNT;
            end
          end else begin
            pos <= pos + POS_W'(1);
            if (bitErr && inData) frameBad <= 1'b1;
          end
        end
      endcase
    end
  end

  AST_LOCK_NEEDS_MARKER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(markerSeen)); // R3

  AST_DROP_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(!markerSeen)); // R7

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    inFrame |-> (pos <= lastPos)); // R6

endmodule

// File: rtl/if_deframer.sv
module if_deframer
  import deframer_pkg::*;
#(
  parameter int SYNC_W = 8,
  parameter logic [SYNC_W-1:0] SYNC_PAT = 8'hA7,
  parameter int I_W = 16,
  parameter int Q_W = 16,
  parameter int G_W = 9,
  parameter int FILL_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dinP,
  input  logic              dinN,
  input  logic [FILL_W-1:0] fillCount,
  output logic [I_W-1:0]    iWord,
  output logic [Q_W-1:0]    qWord,
  output logic [G_W-1:0]    gainWord,
  output logic              sampleValid,
  output logic              locked
);

  dfStrobes_t strobe;
  logic       markerSeen;
  logic       bitErr;

  deframer_control #(
    .SYNC_W(SYNC_W), .I_W(I_W), .Q_W(Q_W), .G_W(G_W), .FILL_W(FILL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .markerSeen(markerSeen), .bitErr(bitErr),
    .fillCount(fillCount), .strobe(strobe), .locked(locked)
  );

  deframer_datapath #(
    .SYNC_W(SYNC_W), .SYNC_PAT(SYNC_PAT), .I_W(I_W), .Q_W(Q_W), .G_W(G_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dinP(dinP), .dinN(dinN), .strobe(strobe),
    .markerSeen(markerSeen), .bitErr(bitErr), .iWord(iWord), .qWord(qWord),
    .gainWord(gainWord), .sampleValid(sampleValid)
  );

  AST_VALID_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> locked); // R4

endmodule

// File: tb/if_deframer_test.sv
`timescale 1ns/1ps
module if_deframer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dinP = 1'b0;
  logic        dinN = 1'b1;
  logic [5:0]  fillCount = '0;
  logic [15:0] iWord;
  logic [15:0] qWord;
  logic [8:0]  gainWord;
  logic        sampleValid;
  logic        locked;

  int checks = 0;
  int errors = 0;
  int gotCnt = 0;
  int expCnt = 0;
  logic [15:0] expI = '0;
  logic [15:0] expQ = '0;
  logic [8:0]  expG = '0;
  bit          expPub = 1'b0;
  string       curTag = "R4";
  bit          prevValid = 1'b0;
  logic [40:0] lastOut = '0;

  always #5 clk = ~clk;

  if_deframer uut (
    .clk(clk), .rstN(rstN), .dinP(dinP), .dinN(dinN), .fillCount(fillCount),
    .iWord(iWord), .qWord(qWord), .gainWord(gainWord),
    .sampleValid(sampleValid), .locked(locked)
  );

  task automatic check(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] genI(input int k);
    return 16'((k * 40503 + 4660) ^ 23614);
  endfunction
  function automatic logic [15:0] genQ(input int k);
    return 16'((k * 9973 + 777) ^ (k << 9));
  endfunction
  function automatic logic [8:0] genG(input int k);
    return 9'(k * 151 + 77);
  endfunction

  task automatic sendBit(input bit b, input bit err);
    @(negedge clk);
    if (err) begin
      dinP = 1'b1;
      dinN = 1'b1;
    end else begin
      dinP = b;
      dinN = !b;
    end
  endtask

  task automatic sendIdle(input int n);
    for (int b = 0; b < n; b++) sendBit(1'b0, 1'b0);
  endtask

  task automatic sendFrame(input logic [7:0] mk, input logic [15:0] iv,
                           input logic [15:0] qv, input logic [8:0] gv,
                           input int fill, input int errPos, input bit pub,
                           input bit lockAfter, input string rq);
    logic [40:0] fb;
    fb = {iv, qv, gv};
    fillCount = 6'(fill);
    for (int b = 7; b >= 0; b--) sendBit(mk[b], 1'b0);
    // previous frame's sample has had time to appear by now
    check(gotCnt == expCnt, "R5 sample count", 64'(gotCnt), 64'(expCnt));
    expI = iv;
    expQ = qv;
    expG = gv;
    expPub = pub;
    curTag = rq;
    if (pub) expCnt++;
    for (int d = 0; d < 41; d++) sendBit(fb[40-d], d == errPos);
    for (int f = 0; f < fill; f++) sendBit(1'b0, (41 + f) == errPos);
    check(locked == lockAfter, {rq, " lock state"}, 64'(locked), 64'(lockAfter));
  endtask

  // output monitor, sampled 3 ns after each rising edge
  always @(posedge clk) begin
    #3;
    if (rstN) begin
      if (sampleValid) begin
        gotCnt++;
        check(!prevValid, "R5 single pulse", 64'(prevValid), 64'd0);
        check(expPub, {curTag, " unexpected sample"}, 64'd1, 64'(expPub));
        if (expPub)
          check({iWord, qWord, gainWord} == {expI, expQ, expG}, "R1,R2 fields",
                64'({iWord, qWord, gainWord}), 64'({expI, expQ, expG}));
        check(locked, "R4 valid while locked", 64'(locked), 64'd1);
        lastOut = {iWord, qWord, gainWord};
      end else if ({iWord, qWord, gainWord} != lastOut) begin
        check(1'b0, "R5 hold", 64'({iWord, qWord, gainWord}), 64'(lastOut));
      end
      prevValid = sampleValid;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(locked == 1'b0, "R9 locked", 64'(locked), 64'd0);
    check(sampleValid == 1'b0, "R9 valid", 64'(sampleValid), 64'd0);
    check({iWord, qWord, gainWord} == '0, "R9 words",
          64'({iWord, qWord, gainWord}), 64'd0);

    sendIdle(20);
    // hunt accept, no output yet
    sendFrame(8'hA7, genI(100), genQ(100), genG(100), 7, -1, 1'b0, 1'b0, "R4");
    // confirmation, then every fill value once in scrambled order
    for (int k = 0; k < 64; k++)
      sendFrame(8'hA7, genI(k), genQ(k), genG(k), (k * 37) % 64, -1,
                1'b1, 1'b1, "R6");

    // line errors
    sendFrame(8'hA7, genI(200), genQ(200), genG(200), 4, 3, 1'b0, 1'b1, "R8");
    sendFrame(8'hA7, genI(201), genQ(201), genG(201), 4, -1, 1'b1, 1'b1, "R8");
    sendFrame(8'hA7, genI(202), genQ(202), genG(202), 2, 40, 1'b0, 1'b1, "R8");
    sendFrame(8'hA7, genI(203), genQ(203), genG(203), 8, 44, 1'b1, 1'b1, "R8");

    // missing marker drops lock, two markers to recover
    sendFrame(8'h00, 16'h0, 16'h0, 9'h0, 0, -1, 1'b0, 1'b0, "R7");
    sendFrame(8'hA7, genI(300), genQ(300), genG(300), 3, -1, 1'b0, 1'b0, "R7");
    sendFrame(8'hA7, genI(301), genQ(301), genG(301), 3, -1, 1'b1, 1'b1, "R7");

    sendIdle(130);
    check(locked == 1'b0, "R7 idle unlock", 64'(locked), 64'd0);

    // wrong spacing: one stray bit
    sendFrame(8'hA7, genI(400), genQ(400), genG(400), 2, -1, 1'b0, 1'b0, "R3");
    sendBit(1'b0, 1'b0);
    sendFrame(8'hA7, genI(401), genQ(401), genG(401), 2, -1, 1'b0, 1'b0, "R3");
    sendFrame(8'hA7, genI(402), genQ(402), genG(402), 2, -1, 1'b1, 1'b1, "R3");

    sendIdle(12);
    check(gotCnt == expCnt, "R5 final count", 64'(gotCnt), 64'(expCnt));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule